// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Bank

This block holds the digital state behind a four-channel digital-to-analog converter. A serial receiver delivers each completed 16-bit command word together with a one-cycle valid strobe. The bank decodes which channel the word targets and whether the word only stages a new code or also commits every staged code to the converter-facing registers in one step. It also decodes a global power-down request that switches all outputs to high impedance.

Each channel keeps two registers. The staging (input) register takes new codes. The output (DAC) register drives the converter. When a commit happens, all four output registers change on the same clock edge, so the channels update together. The resolution parameter selects 8, 10 or 12 bits. The code is always left-aligned in the 12-bit data field of the word, and the output buses are always 12 bits wide.

Top module: `quad_dac_regbank`

## Requirements
- R1: Word bits 15:14 pick the target channel. The value 0 selects channel 0, 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3. Only that channel's staging register takes the new code.
- R2: A valid word with bit 13 at 0 sets `pwr_down` high from the next cycle. A valid word with bit 13 at 1 clears it. The flag holds its value between valid words.
- R3: A valid word with bit 12 at 1 writes only the addressed staging register. No output code changes.
- R4: A valid word with bit 12 at 0 writes the addressed staging register. On the same edge, all four output registers load: the addressed channel takes the new code and the others take their staging values.
- R5: The code is straight binary and sits in bits 11:(12-RES_BITS) of the word. Word bits below that field are ignored. Each 12-bit output carries the code in its upper RES_BITS bits, and the remaining low bits read 0. RES_BITS may only be 8, 10 or 12, and any other value stops elaboration.
- R6: Reset clears all staging and output registers to 0 and drives `pwr_down` to 0.
- R7: While `word_vld` is low, no register and no output changes, whatever `word_in` carries.
- R8: A word that requests power-down still writes the staging register. It also commits the output registers when bit 12 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | One-cycle strobe marking a complete command word |
| word_in | input | 16 | Command word: channel, run bit, stage-only bit, 12-bit data field |
| dac_codes | output | 48 | Four output codes, channel k at bits 12k+11:12k |
| pwr_down | output | 1 | High when all channels are powered down with high-impedance outputs |

## Verification
The assertions assume that `word_vld` marks a fully received word and that `word_in` is stable in the cycle where the strobe is high. They make no assumption about `word_in` in any other cycle. The stimulus drives inputs on the falling clock edge and holds the strobe for exactly one cycle per word. Between words it inserts idle cycles in which `word_in` carries random values. The random words cover every channel, both states of the stage-only bit and both states of the run bit. Directed words add all-zero and all-ones codes and stage-then-commit sequences.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
   localparam int WORD_W  = 16;
   localparam int FIELD_W = 12;
   localparam int NUM_CH  = 4;
   localparam int CH_W    = $clog2(NUM_CH);

   typedef struct packed {
      logic [CH_W-1:0]    chan;
      logic               run;
      logic               stage_only;
      logic [FIELD_W-1:0] field;
   } cmd_word_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
   import dacbank_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic [WORD_W-1:0]   word,
   output logic [NUM_CH-1:0]   wr_sel,
   output logic [FIELD_W-1:0]  code,
   output logic                commit,
   output logic                pd_upd,
   output logic                pd_req
);
   localparam int LOW_W = FIELD_W - RES_BITS;

   cmd_word_t cmd;
   assign cmd = cmd_word_t'(word);

   generate
      if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
         $error("RES_BITS must be 8, 10 or 12");
      end
      if (LOW_W == 0) begin : g_full
         assign code = cmd.field;
      end else begin : g_trim
         assign code = {cmd.field[FIELD_W-1:LOW_W], {LOW_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      wr_sel = '0;
      if (vld) wr_sel[cmd.chan] = 1'b1;
   end

   assign commit = vld & ~cmd.stage_only;
   assign pd_upd = vld;
   assign pd_req = ~cmd.run;

   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> $onehot(wr_sel));
   assert_sel_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> wr_sel == '0 && !commit);
endmodule

// File: rtl/chan_regs.sv
module chan_regs
   import dacbank_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               commit,
   input  logic [FIELD_W-1:0] code_in,
   output logic [FIELD_W-1:0] dac_q
);
   logic [FIELD_W-1:0] inp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inp_q <= '0;
         dac_q <= '0;
      end else begin
         if (wr_en)  inp_q <= code_in;
         if (commit) dac_q <= wr_en ? code_in : inp_q;
      end
   end

   assert_stage_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> inp_q == $past(code_in));
   assert_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(dac_q));
   assert_commit_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> dac_q == inp_q);
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en && !commit |=> $stable(inp_q) && $stable(dac_q));
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic req,
   output logic pwr_down
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pwr_down <= 1'b0;
      else if (upd) pwr_down <= req;
   end

   assert_pd_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd && req |=> pwr_down);
   assert_pd_leave_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !req |=> !pwr_down);
   assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(pwr_down));
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
   import dacbank_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        word_vld,
   input  logic [WORD_W-1:0]           word_in,
   output logic [NUM_CH*FIELD_W-1:0]   dac_codes,
   output logic                        pwr_down
);
   localparam int LOW_W = FIELD_W - RES_BITS;

   logic [NUM_CH-1:0]  wr_sel;
   logic [FIELD_W-1:0] code;
   logic               commit;
   logic               pd_upd;
   logic               pd_req;

   cmd_decode #(.RES_BITS(RES_BITS)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (word_vld),
      .word   (word_in),
      .wr_sel (wr_sel),
      .code   (code),
      .commit (commit),
      .pd_upd (pd_upd),
      .pd_req (pd_req)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      chan_regs u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_sel[k]),
         .commit  (commit),
         .code_in (code),
         .dac_q   (dac_codes[k*FIELD_W +: FIELD_W])
      );
      if (LOW_W > 0) begin : g_low_chk
         assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            dac_codes[k*FIELD_W +: LOW_W] == '0);
      end
   end

   pd_ctrl u_pd (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (pd_upd),
      .req      (pd_req),
      .pwr_down (pwr_down)
   );

   assert_all_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(dac_codes));
endmodule

// File: tb/tb_quad_dac_regbank.sv
module tb_quad_dac_regbank;
   localparam int RES = 12;
   localparam int LOW = 12 - RES;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_vld = 1'b0;
   logic [15:0] word_in = '0;
   logic [47:0] dac_codes;
   logic        pwr_down;

   int total = 0;
   int bad   = 0;
   logic [11:0] inp_m [4];
   logic [11:0] dac_m [4];
   logic        pd_m;

   quad_dac_regbank #(.RES_BITS(RES)) dut (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
      .dac_codes(dac_codes), .pwr_down(pwr_down)
   );

   always #2 clk = ~clk;

   function automatic logic [11:0] exp_code(logic [15:0] w);
      logic [11:0] f = w[11:0];
      for (int b = 0; b < LOW; b++) f[b] = 1'b0;
      return f;
   endfunction

   task automatic check_all(string tag);
      for (int k = 0; k < 4; k++) begin
         total++;
         if (dac_codes[k*12 +: 12] !== dac_m[k]) begin
            bad++;
            $display("FAIL %s ch%0d code act=%h exp=%h", tag, k, dac_codes[k*12 +: 12], dac_m[k]);
         end
      end
      total++;
      if (pwr_down !== pd_m) begin
         bad++;
         $display("FAIL %s pwr_down act=%b exp=%b", tag, pwr_down, pd_m);
      end
   endtask

   task automatic send(logic [15:0] w, string tag);
      @(negedge clk);
      word_in  = w;
      word_vld = 1'b1;
      @(negedge clk);
      word_vld = 1'b0;
      word_in  = 16'($urandom);
      inp_m[w[15:14]] = exp_code(w);
      if (!w[12]) for (int k = 0; k < 4; k++) dac_m[k] = inp_m[k];
      pd_m = ~w[13];
      check_all(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         word_in = 16'($urandom);
      end
      check_all("R7");
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20211));
      for (int k = 0; k < 4; k++) begin inp_m[k] = '0; dac_m[k] = '0; end
      pd_m = 1'b0;
      word_in = 16'hFFFF;
      repeat (3) @(negedge clk);
      check_all("R6");
      rst_n = 1'b1;
      idle(3);
      // R3: stage each channel without commit
      send({2'd0, 2'b11, 12'h123}, "R3");
      send({2'd1, 2'b11, 12'h456}, "R3");
      send({2'd2, 2'b11, 12'h789}, "R3");
      // R4/R1: last channel commits all four
      send({2'd3, 2'b10, 12'hABC}, "R4");
      // R5: extremes of straight binary
      send({2'd2, 2'b10, 12'hFFF}, "R5");
      send({2'd1, 2'b10, 12'h000}, "R5");
      // R2 / R8: power-down with staging then with commit
      send({2'd0, 2'b01, 12'h5A5}, "R8");
      send({2'd3, 2'b00, 12'h0F0}, "R8");
      idle(4);
      send({2'd1, 2'b11, 12'h3C3}, "R2");
      send({2'd0, 2'b10, 12'h777}, "R1");
      for (int i = 0; i < 300; i++) begin
         send(16'($urandom), "R4");
         if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
      end
      // R6: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      for (int k = 0; k < 4; k++) begin inp_m[k] = '0; dac_m[k] = '0; end
      pd_m = 1'b0;
      @(negedge clk);
      check_all("R6");
      rst_n = 1'b1;
      send({2'd2, 2'b10, 12'h001}, "R6");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule